// File: doc/BRIEF.md
# Byte-Wide Parallel Port Controller

This block is a parallel I/O peripheral that hangs on an 8-bit processor bus and gives the processor three 8-bit ports, A, B and C, plus one write-only control register. A chip select, read and write strobes and a two-bit register address pick which of the four registers a bus cycle reaches. Each pad is modelled as three vectors: an input, an output and an output enable. The chip's own pad ring joins them into tristate pins.

The control register takes two kinds of command. If the top bit of the byte is set, the byte sets the port directions. Port A and port B each change direction as a whole byte. Port C has an upper half and a lower half, and each half has its own direction. If the top bit is clear, the byte sets or clears one chosen bit of port C. Only plain latched-output and direct-input operation is built. Mode fields that ask for handshaking or bidirectional operation are ignored, so every port behaves as a simple port.

Top module: `ppi_top`

## Requirements
- R1: After reset every port is an input: all port output enables are low, all output latches are 0 and the data bus is not driven.
- R2: Register address 0 selects port A, 1 selects port B, 2 selects port C and 3 selects the control register, for both reads and writes.
- R3: dat_oe_o is high only when cs_i and rd_i are high, wr_i is low and the address is not 3. In every other case the bus is undriven.
- R4: A read from address 3 is illegal and leaves dat_oe_o low.
- R5: A control byte with bit 7 = 1 sets the directions, with 1 meaning input and 0 meaning output. Bit 4 sets port A, bit 1 sets port B, bit 3 sets port C bits 7:4 and bit 0 sets port C bits 3:0. Each port output-enable bit is the inverse of the direction of its half or port.
- R6: A direction byte clears all three output latches to 0. Its bits 6, 5 and 2 have no effect.
- R7: A control byte with bit 7 = 0 writes the value in bit 0 into the port C bit whose index is in bits 3:1. The other port C bits keep their values.
- R8: One write takes place for each rising edge of the qualified strobe (cs_i and wr_i). It takes effect at the clock edge that first samples the strobe high, using dat_i at that edge. Holding the strobe high does not write again, and a write with cs_i low does nothing.
- R9: A port read returns the live pin values for bits set as inputs and the latch values for bits set as outputs. Port C follows its two halves separately.
- R10: The port output vectors always show the output latches. A data write updates the latch whatever the direction, and the direction gates only the output enables.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| cs_i | input | 1 | Chip select, active high |
| rd_i | input | 1 | Read strobe, active high |
| wr_i | input | 1 | Write strobe, active high |
| addr_i | input | 2 | Register address |
| dat_i | input | 8 | Bus write data |
| dat_o | output | 8 | Bus read data |
| dat_oe_o | output | 1 | Bus drive enable |
| pa_i | input | 8 | Port A pin inputs |
| pa_o | output | 8 | Port A output latch |
| pa_oe_o | output | 8 | Port A output enables |
| pb_i | input | 8 | Port B pin inputs |
| pb_o | output | 8 | Port B output latch |
| pb_oe_o | output | 8 | Port B output enables |
| pc_i | input | 8 | Port C pin inputs |
| pc_o | output | 8 | Port C output latch |
| pc_oe_o | output | 8 | Port C output enables |

## Verification
The hardest case to reach is a write strobe held high across several clock edges while the data bus changes under it. The block must commit only the byte present at the first edge. A directed sequence drives this case with three different data values under one long strobe. A second hard case is port C with its two halves set to opposite directions. Here one read must combine live pins and latched bits, so the random phase draws direction bytes with independent half-port bits, together with fresh pin values on every access.

// File: rtl/ppi_pkg.sv
package ppi_pkg;
  typedef enum logic [1:0] {
    SEL_A    = 2'd0,
    SEL_B    = 2'd1,
    SEL_C    = 2'd2,
    SEL_CTRL = 2'd3
  } sel_e;

  // 1 = input
  typedef struct packed {
    logic a_in;
    logic b_in;
    logic cu_in;
    logic cl_in;
  } dir_t;

  localparam dir_t DIR_RESET = '{a_in: 1'b1, b_in: 1'b1, cu_in: 1'b1, cl_in: 1'b1};
endpackage

// File: rtl/ppi_bus_front.sv
module ppi_bus_front import ppi_pkg::*; (
  input  logic       clk_i,
  input  logic       rst_ni,
  input  logic       cs_i,
  input  logic       rd_i,
  input  logic       wr_i,
  input  logic [1:0] addr_i,
  output sel_e       sel_o,
  output logic       wr_stb_o,
  output logic       rd_en_o
);
  logic stb_now;
  logic stb_q;

  assign sel_o   = sel_e'(addr_i);
  assign stb_now = cs_i & wr_i;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) stb_q <= 1'b0;
    else         stb_q <= stb_now;
  end

  assign wr_stb_o = stb_now & ~stb_q;
  assign rd_en_o  = cs_i & rd_i & ~wr_i & (sel_o != SEL_CTRL);

  AST_STB_SINGLE: assert property (@(posedge clk_i) disable iff (!rst_ni)
    wr_stb_o |=> !wr_stb_o); // R8
  AST_STB_NEEDS_CS: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !cs_i |-> !wr_stb_o); // R8
endmodule

// File: rtl/ppi_ctrl.sv
module ppi_ctrl import ppi_pkg::*; (
  input  logic       clk_i,
  input  logic       rst_ni,
  input  logic       wr_i,
  // {d7, d4, d3, d2, d1, d0} of the control byte
  input  logic [5:0] cw_i,
  output dir_t       dir_o,
  output logic       mode_wr_o,
  output logic       bsr_wr_o,
  output logic [2:0] bsr_idx_o,
  output logic       bsr_val_o
);
  dir_t dir_q;

  assign mode_wr_o = wr_i &  cw_i[5];
  assign bsr_wr_o  = wr_i & ~cw_i[5];
  assign bsr_idx_o = cw_i[3:1];
  assign bsr_val_o = cw_i[0];

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      dir_q <= DIR_RESET;
    end else if (mode_wr_o) begin
      dir_q.a_in  <= cw_i[4];
      dir_q.cu_in <= cw_i[3];
      dir_q.b_in  <= cw_i[1];
      dir_q.cl_in <= cw_i[0];
    end
  end

  assign dir_o = dir_q;

  AST_DIR_HOLD: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !mode_wr_o |=> $stable(dir_o)); // R5
  AST_BSR_KEEPS_DIR: assert property (@(posedge clk_i) disable iff (!rst_ni)
    bsr_wr_o |=> $stable(dir_o)); // R7
endmodule

// File: rtl/ppi_latch.sv
module ppi_latch #(
  parameter int W  = 8,
  localparam int IW = $clog2(W)
) (
  input  logic          clk_i,
  input  logic          rst_ni,
  input  logic          clr_i,
  input  logic          wr_i,
  input  logic [W-1:0]  d_i,
  input  logic          bit_wr_i,
  input  logic [IW-1:0] bit_idx_i,
  input  logic          bit_val_i,
  output logic [W-1:0]  q_o
);
  logic [W-1:0] lat_q;

  for (genvar i = 0; i < W; i++) begin : g_bit
    logic hit;
    assign hit = bit_wr_i & (bit_idx_i == IW'(i));
    always_ff @(posedge clk_i or negedge rst_ni) begin
      if (!rst_ni)    lat_q[i] <= 1'b0;
      else if (clr_i) lat_q[i] <= 1'b0;
      else if (wr_i)  lat_q[i] <= d_i[i];
      else if (hit)   lat_q[i] <= bit_val_i;
    end
  end

  assign q_o = lat_q;

  AST_CLR_ZERO: assert property (@(posedge clk_i) disable iff (!rst_ni)
    clr_i |=> (q_o == '0)); // R6
  AST_HOLD: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !(clr_i || wr_i || bit_wr_i) |=> $stable(q_o)); // R8
  AST_BSR_ONE_BIT: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (bit_wr_i && !clr_i && !wr_i) |=> ($countones(q_o ^ $past(q_o)) <= 1)); // R7
endmodule

// File: rtl/ppi_read_mux.sv
module ppi_read_mux import ppi_pkg::*; #(
  parameter int W = 8,
  parameter int NP = 3
) (
  input  sel_e                  sel_i,
  input  logic [NP-1:0][W-1:0]  pin_i,
  input  logic [NP-1:0][W-1:0]  lat_i,
  input  logic [NP-1:0][W-1:0]  in_mask_i,
  output logic [W-1:0]          dat_o
);
  logic [NP-1:0][W-1:0] val;

  for (genvar p = 0; p < NP; p++) begin : g_port
    assign val[p] = (in_mask_i[p] & pin_i[p]) | (~in_mask_i[p] & lat_i[p]);
  end

  always_comb begin
    unique case (sel_i)
      SEL_A:   dat_o = val[0];
      SEL_B:   dat_o = val[1];
      SEL_C:   dat_o = val[2];
      default: dat_o = '0;
    endcase
  end
endmodule

// File: rtl/ppi_top.sv
module ppi_top import ppi_pkg::*; #(
  parameter int DW = 8
) (
  input  logic          clk_i,
  input  logic          rst_ni,
  input  logic          cs_i,
  input  logic          rd_i,
  input  logic          wr_i,
  input  logic [1:0]    addr_i,
  input  logic [DW-1:0] dat_i,
  output logic [DW-1:0] dat_o,
  output logic          dat_oe_o,
  input  logic [DW-1:0] pa_i,
  output logic [DW-1:0] pa_o,
  output logic [DW-1:0] pa_oe_o,
  input  logic [DW-1:0] pb_i,
  output logic [DW-1:0] pb_o,
  output logic [DW-1:0] pb_oe_o,
  input  logic [DW-1:0] pc_i,
  output logic [DW-1:0] pc_o,
  output logic [DW-1:0] pc_oe_o
);
  localparam int HW = DW / 2;
  localparam int IW = $clog2(DW);
  localparam int NP = 3;

  sel_e        sel;
  logic        wr_stb, rd_en;
  dir_t        dir;
  logic        mode_wr, bsr_wr, bsr_val;
  logic [2:0]  bsr_idx;
  logic [NP-1:0]         port_wr;
  logic [NP-1:0][DW-1:0] lat, pins, in_mask;

  ppi_bus_front u_front (
    .clk_i, .rst_ni, .cs_i, .rd_i, .wr_i, .addr_i,
    .sel_o(sel), .wr_stb_o(wr_stb), .rd_en_o(rd_en)
  );

  ppi_ctrl u_ctrl (
    .clk_i, .rst_ni,
    .wr_i(wr_stb && sel == SEL_CTRL),
    .cw_i({dat_i[7], dat_i[4:0]}),
    .dir_o(dir), .mode_wr_o(mode_wr), .bsr_wr_o(bsr_wr),
    .bsr_idx_o(bsr_idx), .bsr_val_o(bsr_val)
  );

  assign port_wr[0] = wr_stb && sel == SEL_A;
  assign port_wr[1] = wr_stb && sel == SEL_B;
  assign port_wr[2] = wr_stb && sel == SEL_C;

  for (genvar p = 0; p < NP; p++) begin : g_lat
    ppi_latch #(.W(DW)) u_lat (
      .clk_i, .rst_ni,
      .clr_i(mode_wr),
      .wr_i(port_wr[p]),
      .d_i(dat_i),
      .bit_wr_i((p == 2) ? bsr_wr : 1'b0),
      .bit_idx_i(IW'(bsr_idx)),
      .bit_val_i(bsr_val),
      .q_o(lat[p])
    );
  end

  assign in_mask[0] = {DW{dir.a_in}};
  assign in_mask[1] = {DW{dir.b_in}};
  assign in_mask[2] = {{(DW-HW){dir.cu_in}}, {HW{dir.cl_in}}};
  assign pins[0] = pa_i;
  assign pins[1] = pb_i;
  assign pins[2] = pc_i;

  ppi_read_mux #(.W(DW), .NP(NP)) u_rmux (
    .sel_i(sel), .pin_i(pins), .lat_i(lat), .in_mask_i(in_mask), .dat_o(dat_o)
  );

  assign dat_oe_o = rd_en;
  assign pa_o     = lat[0];
  assign pb_o     = lat[1];
  assign pc_o     = lat[2];
  assign pa_oe_o  = ~in_mask[0];
  assign pb_oe_o  = ~in_mask[1];
  assign pc_oe_o  = ~in_mask[2];

  AST_CTRL_RD_HIZ: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (addr_i == 2'd3) |-> !dat_oe_o); // R4
  AST_IDLE_HIZ: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (!cs_i || !rd_i || wr_i) |-> !dat_oe_o); // R3
  AST_PORT_WR_CHANGES_ONE: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (wr_stb && sel == SEL_A) |=> ($stable(pb_o) && $stable(pc_o))); // R2
endmodule

// File: tb/ppi_top_bench.sv
`timescale 1ns/1ps
module ppi_top_bench;
  logic clk = 1'b0, rst_n = 1'b0;
  logic cs = 0, rd = 0, wr = 0;
  logic [1:0] addr = 0;
  logic [7:0] din = 0, dout;
  logic doe;
  logic [7:0] pa_i = 0, pb_i = 0, pc_i = 0;
  logic [7:0] pa_o, pb_o, pc_o, pa_oe, pb_oe, pc_oe;

  int n_run = 0, n_fail = 0;
  bit done = 0;

  // bench model
  bit m_a, m_b, m_cu, m_cl; // 1 = input
  logic [7:0] m_la, m_lb, m_lc;

  always #2 clk = ~clk;

  ppi_top u_ppi_top (
    .clk_i(clk), .rst_ni(rst_n), .cs_i(cs), .rd_i(rd), .wr_i(wr), .addr_i(addr),
    .dat_i(din), .dat_o(dout), .dat_oe_o(doe),
    .pa_i(pa_i), .pa_o(pa_o), .pa_oe_o(pa_oe),
    .pb_i(pb_i), .pb_o(pb_o), .pb_oe_o(pb_oe),
    .pc_i(pc_i), .pc_o(pc_o), .pc_oe_o(pc_oe)
  );

  task automatic chk(input string tag, input logic [7:0] act, input logic [7:0] exp);
    n_run++;
    if (act !== exp) begin
      n_fail++;
      $display("FAIL %s actual=%h expected=%h", tag, act, exp);
    end
  endtask

  function automatic logic [7:0] mask_of(input logic [1:0] a);
    case (a)
      2'd0:    return {8{m_a}};
      2'd1:    return {8{m_b}};
      default: return {{4{m_cu}}, {4{m_cl}}};
    endcase
  endfunction

  function automatic logic [7:0] exp_read(input logic [1:0] a);
    logic [7:0] m, p, l;
    m = mask_of(a);
    p = (a == 0) ? pa_i : (a == 1) ? pb_i : pc_i;
    l = (a == 0) ? m_la : (a == 1) ? m_lb : m_lc;
    return (m & p) | (~m & l);
  endfunction

  task automatic model_write(input logic [1:0] a, input logic [7:0] d);
    case (a)
      2'd0: m_la = d;
      2'd1: m_lb = d;
      2'd2: m_lc = d;
      default:
        if (d[7]) begin
          m_a = d[4]; m_cu = d[3]; m_b = d[1]; m_cl = d[0];
          m_la = 0; m_lb = 0; m_lc = 0;
        end else m_lc[d[3:1]] = d[0];
    endcase
  endtask

  task automatic check_ports(input string tag);
    chk({tag, " pa_o"}, pa_o, m_la);
    chk({tag, " pb_o"}, pb_o, m_lb);
    chk({tag, " pc_o"}, pc_o, m_lc);
    chk({tag, " pa_oe"}, pa_oe, ~mask_of(0));
    chk({tag, " pb_oe"}, pb_oe, ~mask_of(1));
    chk({tag, " pc_oe"}, pc_oe, ~mask_of(2));
  endtask

  task automatic bus_write(input logic [1:0] a, input logic [7:0] d);
    @(negedge clk); cs = 1; wr = 1; rd = 0; addr = a; din = d;
    @(negedge clk); cs = 0; wr = 0;
    model_write(a, d);
    #1;
  endtask

  task automatic bus_read(input logic [1:0] a, input string tag);
    @(negedge clk); cs = 1; rd = 1; wr = 0; addr = a;
    #1;
    if (a == 2'd3) chk({tag, " R4 ctrl read oe"}, {7'd0, doe}, 8'd0);
    else begin
      chk({tag, " R3 oe"}, {7'd0, doe}, 8'd1);
      chk({tag, " R9 data"}, dout, exp_read(a));
    end
    @(negedge clk); cs = 0; rd = 0;
  endtask

  task automatic report;
    $display("[TB] %0d tests run, %0d failed", n_run, n_fail);
    $finish;
  endtask

  initial begin
    repeat (150000) @(posedge clk);
    if (!done) begin
      n_run++; n_fail++;
      $display("FAIL watchdog expired");
      report();
    end
  end

  initial begin
    void'($urandom(32'd1357));
    m_a = 1; m_b = 1; m_cu = 1; m_cl = 1; m_la = 0; m_lb = 0; m_lc = 0;
    repeat (3) @(posedge clk);
    @(negedge clk); rst_n = 1;
    #1;
    // R1 reset state
    check_ports("R1 reset");
    chk("R1 bus idle", {7'd0, doe}, 8'd0);

    // R5 all outputs
    bus_write(3, 8'h80);
    check_ports("R5 all out");
    // R2 R10 address map
    bus_write(0, 8'h5A); bus_write(1, 8'hC3); bus_write(2, 8'h96);
    check_ports("R2 map");
    pa_i = 8'hFF; pb_i = 8'h00; pc_i = 8'hFF;
    bus_read(0, "R2 A"); bus_read(1, "R2 B"); bus_read(2, "R2 C");
    bus_read(3, "R4");

    // R3 deselected read, rd+wr together
    @(negedge clk); cs = 0; rd = 1; addr = 0; #1;
    chk("R3 cs low", {7'd0, doe}, 8'd0);
    @(negedge clk); cs = 1; rd = 1; wr = 1; addr = 1; din = 8'h3C; #1;
    chk("R3 rd+wr", {7'd0, doe}, 8'd0);
    @(negedge clk); cs = 0; rd = 0; wr = 0;
    model_write(1, 8'h3C);
    #1; check_ports("R3 rd+wr write");

    // R8 write with cs low ignored
    @(negedge clk); cs = 0; wr = 1; addr = 0; din = 8'hEE;
    @(negedge clk); wr = 0; #1;
    check_ports("R8 cs low write");

    // R8 held strobe
    @(negedge clk); cs = 1; wr = 1; addr = 0; din = 8'h11;
    @(negedge clk); din = 8'h22;
    @(negedge clk); din = 8'h33;
    @(negedge clk); cs = 0; wr = 0; #1;
    m_la = 8'h11;
    check_ports("R8 held strobe");

    // R7 bit set/reset
    bus_write(3, 8'h0F); // bit 7 set
    bus_write(3, 8'h00); // bit 0 clear
    check_ports("R7 bsr");
    bus_write(3, 8'h0B); // bit 5 set
    check_ports("R7 bsr b5");

    // R6 mode bits 6:5,2 ignored, latches cleared; split C
    bus_write(3, 8'hE4 | 8'h18); // A in, C upper in, B out, C lower out
    check_ports("R6 mode clr");
    pa_i = 8'hA5; pc_i = 8'h7E;
    bus_write(2, 8'hC9);
    bus_read(0, "R9 A in"); bus_read(2, "R9 C split");
    // R10 latch written while input
    bus_write(0, 8'h42);
    check_ports("R10 input latch");

    // random mix
    for (int i = 0; i < 600; i++) begin
      int op;
      logic [7:0] d;
      op = $urandom % 6;
      d = 8'($urandom);
      pa_i = 8'($urandom); pb_i = 8'($urandom); pc_i = 8'($urandom);
      case (op)
        0:       bus_write(3, {1'b1, d[6:0]});
        1:       bus_write(3, {1'b0, d[6:0]});
        2, 3:    bus_write(2'($urandom % 3), d);
        default: bus_read(2'($urandom % 4), "R9 rand");
      endcase
      check_ports("R2 rand");
    end

    done = 1;
    report();
  end
endmodule